// File: doc/BRIEF.md
# Interrupt Cause and Mask Register

This block is one 32-bit control and status word for a network controller. It holds latched interrupt causes (a jabber fault from the transceiver and a system error from the bus-master engine), the enable and mask bits for those causes, and two control bits. The two control bits decide whether a finished transmission should raise the transmit-done flag. The host reads and writes the word through a simple select/write port. Cause bits are write-one-to-clear, so writing back a value just read clears exactly the causes that were pending.

Each bit has its own reset rules. Hard and soft reset return every bit to its default. The stop control clears only the jabber cause. The system-error path raises the interrupt without regard to the global interrupt enable, because that enable is itself dropped by the stop that follows a system error. On every transmit-complete pulse, the block combines the success flag, the descriptor's last-transmit flag and the two control bits into a one-cycle transmit-done set pulse.

Top module: `irq_ctl_reg`

## Requirements
- R1: While hardRst or softRst is high, at the next clock edge the word becomes 0x0000_0001 (only the jabber mask set), and irqOut and txIntSet go to 0.
- R2: Bit layout: bit 1 is the jabber cause, bit 0 the jabber mask, bit 11 the system-error cause, bit 10 the system-error enable, bit 14 the last-transmit mode bit, and bit 15 the success-suppress bit. A write with a 1 in bit 1 or bit 11 clears that cause. A 0 in either bit leaves the cause as it was. Bits 0, 10, 14 and 15 take the written value.
- R3: The jabber cause sets on jabberEv only while link10bt is 1. When link10bt is 0, jabberEv has no effect.
- R4: stopReq clears the jabber cause, even against a jabberEv in the same cycle. It leaves every other bit unchanged.
- R5: The jabber cause contributes to the interrupt only when globIntEn is 1 and the jabber mask is 0.
- R6: Any of parErrEv, mstAbortEv or tgtAbortEv sets the system-error cause. With its enable at 1, that cause raises the interrupt whatever globIntEn is.
- R7: When a hardware set event and a host write-one-to-clear hit the same cause in the same cycle, the cause ends up set.
- R8: With bits 14 and 15 both 0, every txDoneEv gives a one-cycle txIntSet pulse in the following cycle, whatever txOk is. With no txDoneEv there is no pulse.
- R9: With bit 15 at 1 and bit 14 at 0, a txDoneEv with txOk=1 gives no pulse. A txDoneEv with txOk=0 gives a pulse.
- R10: With bit 14 at 1, the pulse after a txDoneEv equals txLastFlag, whatever txOk and bit 15 are.
- R11: Bits 31..16, 13..12 and 9..2 always read 0, and writes to them have no effect.
- R12: irqOut is registered. In each cycle it equals the OR of (jabber cause AND NOT mask AND globIntEn) and (system-error cause AND its enable), taken from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hardRst | input | 1 | Hard reset, synchronous, active high |
| softRst | input | 1 | Soft reset, synchronous, active high |
| stopReq | input | 1 | Stop control; clears the jabber cause |
| regSel | input | 1 | Host access targets this register |
| regWr | input | 1 | Host write strobe |
| wrData | input | 32 | Host write data |
| rdData | output | 32 | Current register contents |
| jabberEv | input | 1 | Transceiver reports transmit time limit exceeded |
| parErrEv | input | 1 | Data parity error in a bus-master transfer |
| mstAbortEv | input | 1 | Master abort in a bus-master transfer |
| tgtAbortEv | input | 1 | Target abort in a bus-master transfer |
| txDoneEv | input | 1 | Transmission finished |
| txOk | input | 1 | The finished transmission succeeded |
| txLastFlag | input | 1 | Last-transmit flag from the transmit descriptor |
| globIntEn | input | 1 | Global interrupt enable |
| link10bt | input | 1 | Link is in 10BASE-T mode |
| irqOut | output | 1 | Interrupt request |
| txIntSet | output | 1 | One-cycle pulse that sets the transmit-done flag |

## Verification
On every cycle after reset, the assertions check the following: the registered interrupt equation, the reserved bits reading zero, the stop clearing jabber, the jabber gate on link mode, set-over-clear for the system error, and the transmit pulse following the descriptor flag in last-transmit mode. The bench scenarios are needed for the rest. They cover the exact reset value, write-one-to-clear against write-zero, stop leaving the other bits alone, the global-enable bypass of the system-error path, and the success-suppress pulse rules. A cycle-level reference model in the bench predicts all three outputs after every clock edge.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int REG_W    = 32;
  localparam int TOKD_POS = 15;
  localparam int LTE_POS  = 14;
  localparam int SYS_POS  = 11;
  localparam int SYSE_POS = 10;

  typedef struct packed {
    logic initAll;
    logic jabSet;
    logic jabClr;
    logic sysSet;
    logic sysClr;
    logic ctrlLoad;
    logic txFlag;
  } strobe_t;
endpackage

// File: rtl/irq_ctl_ctrl.sv
module irq_ctl_ctrl
  import irq_ctl_pkg::*;
#(
  parameter int JAB_POS  = 1,
  parameter int JABM_POS = 0
) (
  input  logic             hardRst,
  input  logic             softRst,
  input  logic             stopReq,
  input  logic             regSel,
  input  logic             regWr,
  input  logic [REG_W-1:0] wrData,
  input  logic             jabberEv,
  input  logic             parErrEv,
  input  logic             mstAbortEv,
  input  logic             tgtAbortEv,
  input  logic             txDoneEv,
  input  logic             txOk,
  input  logic             txLastFlag,
  input  logic             link10bt,
  input  logic             lteBit,
  input  logic             tokdBit,
  output strobe_t          stb
);
  logic wrHit;
  logic unusedWrBits;

  assign wrHit = regSel & regWr;
  assign unusedWrBits = ^wrData;

  always_comb begin
    stb = '0;
    stb.initAll  = hardRst | softRst;
    // Stop overrides a simultaneous jabber report.
    stb.jabSet   = jabberEv & link10bt & ~stopReq;
    stb.jabClr   = stopReq | (wrHit & wrData[JAB_POS]);
    stb.sysSet   = parErrEv | mstAbortEv | tgtAbortEv;
    stb.sysClr   = wrHit & wrData[SYS_POS];
    stb.ctrlLoad = wrHit;
    if (lteBit)
      stb.txFlag = txDoneEv & txLastFlag;
    else
      stb.txFlag = txDoneEv & (~txOk | ~tokdBit);
  end
endmodule

// File: rtl/irq_ctl_dp.sv
module irq_ctl_dp
  import irq_ctl_pkg::*;
#(
  parameter int JAB_POS  = 1,
  parameter int JABM_POS = 0
) (
  input  logic             clk,
  input  strobe_t          stb,
  input  logic [REG_W-1:0] wrData,
  input  logic             globIntEn,
  output logic [REG_W-1:0] rdData,
  output logic             irqOut,
  output logic             txIntSet,
  output logic             lteBit,
  output logic             tokdBit
);
  logic jabFlag, jabMask, sysFlag, sysEn;
  logic irqNext;
  logic unusedWrBits;

  assign unusedWrBits = ^wrData;
  assign irqNext = (jabFlag & ~jabMask & globIntEn) | (sysFlag & sysEn);

  always_ff @(posedge clk) begin
    if (stb.initAll) begin
      jabFlag  <= 1'b0;
      jabMask  <= 1'b1;
      sysFlag  <= 1'b0;
      sysEn    <= 1'b0;
      lteBit   <= 1'b0;
      tokdBit  <= 1'b0;
      irqOut   <= 1'b0;
      txIntSet <= 1'b0;
    end else begin
      if (stb.jabSet)      jabFlag <= 1'b1;
      else if (stb.jabClr) jabFlag <= 1'b0;
      if (stb.sysSet)      sysFlag <= 1'b1;
      else if (stb.sysClr) sysFlag <= 1'b0;
      if (stb.ctrlLoad) begin
        jabMask <= wrData[JABM_POS];
        sysEn   <= wrData[SYSE_POS];
        lteBit  <= wrData[LTE_POS];
        tokdBit <= wrData[TOKD_POS];
      end
      irqOut   <= irqNext;
      txIntSet <= stb.txFlag;
    end
  end

  always_comb begin
    rdData           = '0;
    rdData[JAB_POS]  = jabFlag;
    rdData[JABM_POS] = jabMask;
    rdData[SYS_POS]  = sysFlag;
    rdData[SYSE_POS] = sysEn;
    rdData[LTE_POS]  = lteBit;
    rdData[TOKD_POS] = tokdBit;
  end
endmodule

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg
  import irq_ctl_pkg::*;
#(
  parameter int JAB_POS  = 1,
  parameter int JABM_POS = 0
) (
  input  logic        clk,
  input  logic        hardRst,
  input  logic        softRst,
  input  logic        stopReq,
  input  logic        regSel,
  input  logic        regWr,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  input  logic        jabberEv,
  input  logic        parErrEv,
  input  logic        mstAbortEv,
  input  logic        tgtAbortEv,
  input  logic        txDoneEv,
  input  logic        txOk,
  input  logic        txLastFlag,
  input  logic        globIntEn,
  input  logic        link10bt,
  output logic        irqOut,
  output logic        txIntSet
);
  strobe_t stb;
  logic    lteBit, tokdBit;

  irq_ctl_ctrl #(.JAB_POS(JAB_POS), .JABM_POS(JABM_POS)) u_ctrl (
    .hardRst(hardRst), .softRst(softRst), .stopReq(stopReq),
    .regSel(regSel), .regWr(regWr), .wrData(wrData),
    .jabberEv(jabberEv), .parErrEv(parErrEv), .mstAbortEv(mstAbortEv),
    .tgtAbortEv(tgtAbortEv), .txDoneEv(txDoneEv), .txOk(txOk),
    .txLastFlag(txLastFlag), .link10bt(link10bt),
    .lteBit(lteBit), .tokdBit(tokdBit), .stb(stb)
  );

  irq_ctl_dp #(.JAB_POS(JAB_POS), .JABM_POS(JABM_POS)) u_dp (
    .clk(clk), .stb(stb), .wrData(wrData), .globIntEn(globIntEn),
    .rdData(rdData), .irqOut(irqOut), .txIntSet(txIntSet),
    .lteBit(lteBit), .tokdBit(tokdBit)
  );
endmodule

// File: rtl/irq_ctl_chk.sv
module irq_ctl_chk #(
  parameter int JAB_POS  = 1,
  parameter int JABM_POS = 0
) (
  input logic        clk,
  input logic        hardRst,
  input logic        softRst,
  input logic        stopReq,
  input logic        regSel,
  input logic        regWr,
  input logic [31:0] wrData,
  input logic [31:0] rdData,
  input logic        jabberEv,
  input logic        parErrEv,
  input logic        mstAbortEv,
  input logic        tgtAbortEv,
  input logic        txDoneEv,
  input logic        txLastFlag,
  input logic        globIntEn,
  input logic        link10bt,
  input logic        irqOut,
  input logic        txIntSet
);
  localparam logic [31:0] LIVE_BITS = (32'(1) << 15) | (32'(1) << 14) |
    (32'(1) << 11) | (32'(1) << 10) | (32'(1) << JAB_POS) | (32'(1) << JABM_POS);

  logic rstAny, armed;
  assign rstAny = hardRst | softRst;

  // Set one cycle after reset ends, so $past never reaches into reset.
  always_ff @(posedge clk) begin
    if (rstAny) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  p_irq_eq_r12: assert property (@(posedge clk) disable iff (rstAny)
    armed |-> irqOut == $past((rdData[JAB_POS] & ~rdData[JABM_POS] & globIntEn) |
                              (rdData[11] & rdData[10])));

  p_reserved_zero_r11: assert property (@(posedge clk) disable iff (rstAny)
    (rdData & ~LIVE_BITS) == 32'h0);

  p_stop_clears_r4: assert property (@(posedge clk) disable iff (rstAny)
    armed && $past(stopReq) |-> !rdData[JAB_POS]);

  p_jab_link_gate_r3: assert property (@(posedge clk) disable iff (rstAny)
    armed && !$past(link10bt) && !$past(rdData[JAB_POS]) |-> !rdData[JAB_POS]);

  p_set_wins_r7: assert property (@(posedge clk) disable iff (rstAny)
    armed && $past(regSel && regWr && wrData[11] && (parErrEv || mstAbortEv || tgtAbortEv))
    |-> rdData[11]);

  p_sys_any_event_r6: assert property (@(posedge clk) disable iff (rstAny)
    armed && $past(parErrEv || mstAbortEv || tgtAbortEv) |-> rdData[11]);

  p_last_mode_r10: assert property (@(posedge clk) disable iff (rstAny)
    armed && $past(txDoneEv && rdData[14]) |-> txIntSet == $past(txLastFlag));

  p_no_spurious_tx_r8: assert property (@(posedge clk) disable iff (rstAny)
    armed && !$past(txDoneEv) |-> !txIntSet);
endmodule

bind irq_ctl_reg irq_ctl_chk #(.JAB_POS(JAB_POS), .JABM_POS(JABM_POS)) u_chk (
  .clk(clk), .hardRst(hardRst), .softRst(softRst), .stopReq(stopReq),
  .regSel(regSel), .regWr(regWr), .wrData(wrData), .rdData(rdData),
  .jabberEv(jabberEv), .parErrEv(parErrEv), .mstAbortEv(mstAbortEv),
  .tgtAbortEv(tgtAbortEv), .txDoneEv(txDoneEv), .txLastFlag(txLastFlag),
  .globIntEn(globIntEn), .link10bt(link10bt), .irqOut(irqOut), .txIntSet(txIntSet)
);

// File: tb/irq_ctl_reg_test.sv
module irq_ctl_reg_test;
  logic clk = 1'b0;
  logic hardRst = 1'b1, softRst = 1'b0, stopReq = 1'b0;
  logic regSel = 1'b1, regWr = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic jabberEv = 0, parErrEv = 0, mstAbortEv = 0, tgtAbortEv = 0;
  logic txDoneEv = 0, txOk = 0, txLastFlag = 0, globIntEn = 0, link10bt = 0;
  logic irqOut, txIntSet;

  always #5 clk = ~clk;

  irq_ctl_reg uut (
    .clk(clk), .hardRst(hardRst), .softRst(softRst), .stopReq(stopReq),
    .regSel(regSel), .regWr(regWr), .wrData(wrData), .rdData(rdData),
    .jabberEv(jabberEv), .parErrEv(parErrEv), .mstAbortEv(mstAbortEv),
    .tgtAbortEv(tgtAbortEv), .txDoneEv(txDoneEv), .txOk(txOk),
    .txLastFlag(txLastFlag), .globIntEn(globIntEn), .link10bt(link10bt),
    .irqOut(irqOut), .txIntSet(txIntSet)
  );

  typedef struct {
    string       tag;
    logic [31:0] rd;
    logic        irq;
    logic        tx;
  } exp_t;

  exp_t expQ[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference model state, built from the requirements.
  logic mJab = 0, mJabM = 1, mSys = 0, mSysE = 0, mLte = 0, mTokd = 0;

  task automatic tick(input string tag);
    exp_t e;
    logic wr, nJab, nJabM, nSys, nSysE, nLte, nTokd, nIrq, nTx;
    wr    = regSel & regWr;
    nIrq  = (mJab & ~mJabM & globIntEn) | (mSys & mSysE);
    nTx   = txDoneEv & (mLte ? txLastFlag : (txOk ? ~mTokd : 1'b1));
    nJab  = stopReq ? 1'b0 : (jabberEv & link10bt) ? 1'b1 : (wr & wrData[1]) ? 1'b0 : mJab;
    nSys  = (parErrEv | mstAbortEv | tgtAbortEv) ? 1'b1 : (wr & wrData[11]) ? 1'b0 : mSys;
    nJabM = wr ? wrData[0]  : mJabM;
    nSysE = wr ? wrData[10] : mSysE;
    nLte  = wr ? wrData[14] : mLte;
    nTokd = wr ? wrData[15] : mTokd;
    if (hardRst | softRst) begin
      nJab = 0; nJabM = 1; nSys = 0; nSysE = 0; nLte = 0; nTokd = 0; nIrq = 0; nTx = 0;
    end
    e.tag = tag;
    e.rd  = '0;
    e.rd[1] = nJab; e.rd[0] = nJabM; e.rd[11] = nSys; e.rd[10] = nSysE;
    e.rd[14] = nLte; e.rd[15] = nTokd;
    e.irq = nIrq;
    e.tx  = nTx;
    @(posedge clk);
    #1;
    expQ.push_back(e);
    mJab = nJab; mJabM = nJabM; mSys = nSys; mSysE = nSysE; mLte = nLte; mTokd = nTokd;
    @(negedge clk);
    hardRst = 0; softRst = 0; stopReq = 0; regWr = 0;
    jabberEv = 0; parErrEv = 0; mstAbortEv = 0; tgtAbortEv = 0; txDoneEv = 0;
  endtask

  task automatic hostWrite(input logic [31:0] d, input string tag);
    regWr = 1; wrData = d;
    tick(tag);
  endtask

  // Monitor: compares design outputs against queued expectations.
  always @(negedge clk) begin
    while (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      checks++;
      if (rdData !== e.rd || irqOut !== e.irq || txIntSet !== e.tx) begin
        errors++;
        $display("FAIL %s: actual rd=%h irq=%b tx=%b expected rd=%h irq=%b tx=%b",
                 e.tag, rdData, irqOut, txIntSet, e.rd, e.irq, e.tx);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all): actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    hardRst = 1; tick("R1");
    // Reserved bits ignore writes; sys enable on, jabber mask off.
    hostWrite(32'hFFFF_33FC | 32'h0000_0400, "R11");
    link10bt = 0; jabberEv = 1; tick("R3");
    link10bt = 1; jabberEv = 1; tick("R3");
    globIntEn = 0; tick("R5");
    globIntEn = 1; tick("R5");
    tick("R12");
    hostWrite(32'h0000_0400, "R2");
    hostWrite(32'h0000_0402, "R2");
    tick("R12");
    jabberEv = 1; tick("R3");
    stopReq = 1; jabberEv = 1; tick("R4");
    tick("R4");
    hostWrite(32'h0000_0401, "R5");
    jabberEv = 1; tick("R5");
    tick("R5");
    globIntEn = 0; parErrEv = 1; tick("R6");
    tick("R6");
    hostWrite(32'h0000_0C03, "R2");
    mstAbortEv = 1; tick("R6");
    hostWrite(32'h0000_0C01, "R6");
    tgtAbortEv = 1; tick("R6");
    regWr = 1; wrData = 32'h0000_0C01; tgtAbortEv = 1; tick("R7");
    tick("R7");
    stopReq = 1; tick("R4");
    softRst = 1; tick("R1");
    tick("R1");
    txDoneEv = 1; txOk = 1; tick("R8");
    txDoneEv = 1; txOk = 0; tick("R8");
    tick("R8");
    hostWrite(32'h0000_8001, "R9");
    txDoneEv = 1; txOk = 1; tick("R9");
    txDoneEv = 1; txOk = 0; tick("R9");
    hostWrite(32'h0000_C001, "R10");
    txDoneEv = 1; txOk = 0; txLastFlag = 0; tick("R10");
    txDoneEv = 1; txOk = 1; txLastFlag = 1; tick("R10");
    hostWrite(32'h0000_4001, "R10");
    txDoneEv = 1; txOk = 1; txLastFlag = 0; tick("R10");
    tick("R10");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule